// File: doc/BRIEF.md
# Branch-Aware Fetch Controller

This block owns the program counter and the fetch stage of an eight-stage in-order pipeline. Every branch is resolved at the end of the third stage. The controller decides in each cycle whether to fetch and which address to fetch. It also decides which of the younger instructions already in flight must be turned into bubbles. It tracks the valid and branch flags of the instructions in decode and register-read. When a branch reaches the third stage, it uses the resolution inputs presented in that cycle: the actual direction, the actual target and the mispredict flag.

Four branch policies can be selected at run time. Stall-on-branch stops fetching until the branch resolves. Sequential fetch keeps going at PC+4 and kills the wrong-path work when a branch turns out taken. Delay-slot mode always fetches and keeps the instruction that follows a branch, then waits for resolution. Predictor mode follows a direction and target supplied from outside and recovers when a mispredict is reported. A free-running cycle counter and a counter of valid instructions that leave the last stage let a test compute cycles per instruction for any mix of branches.

Top module: `brf_fetch_ctrl`

## Requirements
- R1: A synchronous active-high reset loads the PC with RESET_VEC, clears both counters and all stage valid bits, and captures the policy input. In the first cycle after reset, fetch is enabled at RESET_VEC.
- R2: When a fetched instruction is not a branch and no squash is signalled, the next fetch address is the current one plus 4.
- R3: Policy code 0 (stall): fetch is disabled in the two cycles after a branch is fetched. In the third cycle it resumes at the target if the branch is taken, or at the branch address plus 4 if not. A branch therefore costs 3 fetch cycles.
- R4: Policy code 1 (sequential): fetch never pauses. When the third stage resolves a branch as taken, squash_o is high in that cycle and the two younger instructions are dropped. The next fetch is at the target. A not-taken branch costs nothing.
- R5: Policy code 2 (delay slot): the instruction at branch address plus 4 is fetched in the next cycle and is never dropped. Its branch flag is ignored. Fetch is off in the cycle after that, then resumes at the target if taken, or at branch address plus 8 if not taken.
- R6: Policy code 3 (predictor): when a branch is fetched, the next fetch address is pred_target_i if pred_taken_i is high, and branch address plus 4 otherwise. A correct prediction causes no squash and no gap.
- R7: Policy code 3: when rs_mispred_i is high while a branch is in the third stage, squash_o is high, the two younger instructions are dropped, and the next fetch is at rs_target_i if taken or at branch address plus 4 if not taken.
- R8: squash_o is never high under policies 0 and 2. A squashed instruction never reaches the retire count, and after a squash the decode stage holds a bubble.
- R9: retire_cnt_o counts valid instructions that leave stage 8. An instruction fetched in cycle k is counted from cycle k+8 onward. The counter grows by at most 1 per cycle.
- R10: cycle_cnt_o is 0 in the first cycle after reset and grows by exactly 1 per cycle.
- R11: The policy input is taken in only on a clock edge where no branch is being fetched and none is in decode or register-read. A change made while a branch is in flight only affects branches fetched after that branch has resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Branch policy: 0 stall, 1 sequential, 2 delay slot, 3 predictor |
| if_is_br_i | input | 1 | The instruction at fetch_pc_o is a branch |
| pred_taken_i | input | 1 | Predicted direction for the branch being fetched |
| pred_target_i | input | PCW | Predicted target for the branch being fetched |
| rs_taken_i | input | 1 | Actual direction of the branch in stage 3 |
| rs_target_i | input | PCW | Actual target of the branch in stage 3 |
| rs_mispred_i | input | 1 | Prediction for the branch in stage 3 was wrong |
| fetch_en_o | output | 1 | Fetch is performed this cycle |
| fetch_pc_o | output | PCW | Address fetched this cycle |
| squash_o | output | 1 | Younger instructions are being dropped this cycle |
| dec_valid_o | output | 1 | Decode stage holds a valid instruction |
| rr_valid_o | output | 1 | Register-read stage holds a valid instruction |
| cycle_cnt_o | output | CW | Cycles since reset |
| retire_cnt_o | output | CW | Valid instructions that have left stage 8 |

## Verification
The hardest situation to reach is a policy change while a branch is still in flight. The new code must be held off until the branch resolves, and the old policy must still govern that branch. The stimulus starts in stall mode with a branch at the reset vector. It moves the policy input to sequential one cycle later, while that branch sits in decode. Then it checks that the first branch pays the full stall and later branches follow the sequential pattern. Mispredicts in both directions are produced by holding the predictor inputs opposite to the actual outcome. Each fetch cycle, squash and retire total is compared against a stream of expected items built from the policy rules.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [1:0] {
    POL_STALL = 2'd0,
    POL_SEQ   = 2'd1,
    POL_SLOT  = 2'd2,
    POL_PRED  = 2'd3
  } policy_e;
endpackage

// File: rtl/brf_pipe.sv
// Valid/branch tracking for decode and register-read, plus the valid chain
// through the remaining stages up to the last one.
module brf_pipe #(
  parameter int PCW  = 32,
  parameter int NSTG = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic           in_br,
  input  logic [PCW-1:0] in_pc,
  input  logic           kill,
  output logic           dec_vld,
  output logic           dec_br,
  output logic           rr_vld,
  output logic           rr_br,
  output logic [PCW-1:0] rr_pc,
  output logic           tail_vld
);
  localparam int NTAIL = NSTG - 3;

  logic           dec_vld_q, dec_br_q, rr_vld_q, rr_br_q;
  logic [PCW-1:0] dec_pc_q, rr_pc_q;
  logic [NTAIL-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld_q <= 1'b0;
      dec_br_q  <= 1'b0;
      dec_pc_q  <= '0;
      rr_vld_q  <= 1'b0;
      rr_br_q   <= 1'b0;
      rr_pc_q   <= '0;
    end else begin
      dec_vld_q <= in_vld & ~kill;
      dec_br_q  <= in_br & in_vld & ~kill;
      dec_pc_q  <= in_pc;
      rr_vld_q  <= dec_vld_q & ~kill;
      rr_br_q   <= dec_br_q & ~kill;
      rr_pc_q   <= dec_pc_q;
    end
  end

  for (genvar g = 0; g < NTAIL; g++) begin : g_tail
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) tail_q[g] <= 1'b0;
        else     tail_q[g] <= rr_vld_q;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) tail_q[g] <= 1'b0;
        else     tail_q[g] <= tail_q[g-1];
      end
    end
  end

  assign dec_vld  = dec_vld_q;
  assign dec_br   = dec_br_q;
  assign rr_vld   = rr_vld_q;
  assign rr_br    = rr_br_q;
  assign rr_pc    = rr_pc_q;
  assign tail_vld = tail_q[NTAIL-1];
endmodule

// File: rtl/brf_policy.sv
// Per-policy fetch gating, squash decision and next-PC selection.
module brf_policy
  import brf_pkg::*;
#(
  parameter int PCW = 32
) (
  input  policy_e        mode,
  input  logic [PCW-1:0] pc,
  input  logic           if_br,
  input  logic           dec_vld,
  input  logic           dec_br,
  input  logic           rr_vld,
  input  logic           rr_br,
  input  logic [PCW-1:0] rr_pc,
  input  logic           pred_taken,
  input  logic [PCW-1:0] pred_target,
  input  logic           rs_taken,
  input  logic [PCW-1:0] rs_target,
  input  logic           rs_mispred,
  output logic           fetch_en,
  output logic           br_eff,
  output logic           kill,
  output logic [PCW-1:0] pc_nxt
);
  localparam logic [PCW-1:0] STEP  = PCW'(4);
  localparam logic [PCW-1:0] STEP2 = PCW'(8);

  logic br_in_dec, resolve, redirect;
  logic [PCW-1:0] corr_pc, seq_pc;

  assign br_in_dec = dec_vld & dec_br;
  assign resolve   = rr_vld & rr_br;

  always_comb begin
    case (mode)
      POL_STALL: fetch_en = ~br_in_dec & ~resolve;
      POL_SLOT:  fetch_en = ~resolve;
      default:   fetch_en = 1'b1;
    endcase
  end

  // the delay-slot fetch never counts as a branch
  assign br_eff = if_br & fetch_en & ~((mode == POL_SLOT) & br_in_dec);

  always_comb begin
    if (rs_taken)              corr_pc = rs_target;
    else if (mode == POL_SLOT) corr_pc = rr_pc + STEP2;
    else                       corr_pc = rr_pc + STEP;
  end

  assign kill = resolve & (((mode == POL_SEQ) & rs_taken) |
                           ((mode == POL_PRED) & rs_mispred));
  assign redirect = kill | (resolve & ((mode == POL_STALL) | (mode == POL_SLOT)));

  assign seq_pc = ((mode == POL_PRED) & br_eff & pred_taken) ? pred_target : pc + STEP;

  always_comb begin
    if (redirect)      pc_nxt = corr_pc;
    else if (fetch_en) pc_nxt = seq_pc;
    else               pc_nxt = pc;
  end
endmodule

// File: rtl/brf_counters.sv
module brf_counters #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire,
  output logic [CW-1:0] cycles,
  output logic [CW-1:0] retired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycles  <= '0;
      retired <= '0;
    end else begin
      cycles  <= cycles + CW'(1);
      retired <= retired + CW'(retire);
    end
  end
endmodule

// File: rtl/brf_fetch_ctrl.sv
module brf_fetch_ctrl
  import brf_pkg::*;
#(
  parameter int             PCW       = 32,
  parameter int             CW        = 32,
  parameter int             NSTG      = 8,
  parameter logic [PCW-1:0] RESET_VEC = PCW'(32'h0000_0100)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_i,
  input  logic           if_is_br_i,
  input  logic           pred_taken_i,
  input  logic [PCW-1:0] pred_target_i,
  input  logic           rs_taken_i,
  input  logic [PCW-1:0] rs_target_i,
  input  logic           rs_mispred_i,
  output logic           fetch_en_o,
  output logic [PCW-1:0] fetch_pc_o,
  output logic           squash_o,
  output logic           dec_valid_o,
  output logic           rr_valid_o,
  output logic [CW-1:0]  cycle_cnt_o,
  output logic [CW-1:0]  retire_cnt_o
);
  policy_e        mode_q;
  logic [PCW-1:0] pc_q, pc_nxt, rr_pc;
  logic           fetch_en, br_eff, kill;
  logic           dec_vld, dec_br, rr_vld, rr_br, tail_vld;
  logic           in_flight;

  brf_policy #(.PCW(PCW)) u_pol (
    .mode(mode_q), .pc(pc_q), .if_br(if_is_br_i),
    .dec_vld(dec_vld), .dec_br(dec_br), .rr_vld(rr_vld), .rr_br(rr_br),
    .rr_pc(rr_pc), .pred_taken(pred_taken_i), .pred_target(pred_target_i),
    .rs_taken(rs_taken_i), .rs_target(rs_target_i), .rs_mispred(rs_mispred_i),
    .fetch_en(fetch_en), .br_eff(br_eff), .kill(kill), .pc_nxt(pc_nxt)
  );

  brf_pipe #(.PCW(PCW), .NSTG(NSTG)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(fetch_en), .in_br(br_eff), .in_pc(pc_q),
    .kill(kill), .dec_vld(dec_vld), .dec_br(dec_br), .rr_vld(rr_vld),
    .rr_br(rr_br), .rr_pc(rr_pc), .tail_vld(tail_vld)
  );

  brf_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .retire(tail_vld),
    .cycles(cycle_cnt_o), .retired(retire_cnt_o)
  );

  assign in_flight = br_eff | (dec_vld & dec_br) | (rr_vld & rr_br);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_VEC;
      mode_q <= policy_e'(mode_i);
    end else begin
      pc_q <= pc_nxt;
      if (!in_flight) mode_q <= policy_e'(mode_i);
    end
  end

  assign fetch_en_o  = fetch_en;
  assign fetch_pc_o  = pc_q;
  assign squash_o    = kill;
  assign dec_valid_o = dec_vld;
  assign rr_valid_o  = rr_vld;
endmodule

// File: rtl/brf_fetch_ctrl_chk.sv
module brf_fetch_ctrl_chk
  import brf_pkg::*;
#(
  parameter int             PCW       = 32,
  parameter int             CW        = 32,
  parameter logic [PCW-1:0] RESET_VEC = PCW'(32'h0000_0100)
) (
  input logic           clk,
  input logic           rst,
  input logic           if_is_br_i,
  input logic           fetch_en_o,
  input logic [PCW-1:0] fetch_pc_o,
  input logic           squash_o,
  input logic           dec_valid_o,
  input logic [CW-1:0]  cycle_cnt_o,
  input logic [CW-1:0]  retire_cnt_o,
  input policy_e        mode_q,
  input logic           dec_vld,
  input logic           dec_br,
  input logic           rr_vld,
  input logic           rr_br
);
  AST_RESET_VECTOR: assert property (@(posedge clk) $fell(rst) |-> fetch_en_o && fetch_pc_o == RESET_VEC); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) fetch_en_o && !if_is_br_i && !squash_o |=> fetch_pc_o == $past(fetch_pc_o) + PCW'(4)); // R2
  AST_STALL_GAP: assert property (@(posedge clk) disable iff (rst) fetch_en_o && if_is_br_i && mode_q == POL_STALL |=> !fetch_en_o ##1 !fetch_en_o); // R3
  AST_SLOT_GAP: assert property (@(posedge clk) disable iff (rst) fetch_en_o && if_is_br_i && mode_q == POL_SLOT |=> fetch_en_o ##1 !fetch_en_o); // R5
  AST_SQUASH_MODE: assert property (@(posedge clk) disable iff (rst) squash_o |-> mode_q == POL_SEQ || mode_q == POL_PRED); // R8
  AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst) squash_o |=> !dec_valid_o); // R8
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (retire_cnt_o - $past(retire_cnt_o)) <= CW'(1)); // R9
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> cycle_cnt_o == $past(cycle_cnt_o) + CW'(1)); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) (dec_vld && dec_br) || (rr_vld && rr_br) |=> $stable(mode_q)); // R11
endmodule

bind brf_fetch_ctrl brf_fetch_ctrl_chk #(.PCW(PCW), .CW(CW), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .if_is_br_i(if_is_br_i), .fetch_en_o(fetch_en_o),
  .fetch_pc_o(fetch_pc_o), .squash_o(squash_o), .dec_valid_o(dec_valid_o),
  .cycle_cnt_o(cycle_cnt_o), .retire_cnt_o(retire_cnt_o), .mode_q(mode_q),
  .dec_vld(dec_vld), .dec_br(dec_br), .rr_vld(rr_vld), .rr_br(rr_br)
);

// File: tb/sim_brf_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_brf_fetch_ctrl;
  localparam logic [31:0] RV  = 32'h0000_0100;
  localparam logic [31:0] TGT = 32'h0000_0280;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'd0;
  logic        br_in;
  logic        pred_taken = 1'b0, rs_taken = 1'b0, rs_mispred = 1'b0;
  logic        fetch_en, squash, dec_valid, rr_valid;
  logic [31:0] fetch_pc, cycle_cnt, retire_cnt;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  string tag = "R1";
  int mcyc = 0;

  typedef struct {
    logic        en;
    logic [31:0] pc;
    logic        sq;
  } item_t;
  item_t exp_q[$];
  int g_idx, g_use, g_n;

  always #10 clk = ~clk;

  function automatic logic is_br(input logic [31:0] a);
    return ((a >> 2) % 32'd5) == 32'd4;
  endfunction

  assign br_in = is_br(fetch_pc);

  brf_fetch_ctrl u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .if_is_br_i(br_in),
    .pred_taken_i(pred_taken), .pred_target_i(TGT), .rs_taken_i(rs_taken),
    .rs_target_i(TGT), .rs_mispred_i(rs_mispred), .fetch_en_o(fetch_en),
    .fetch_pc_o(fetch_pc), .squash_o(squash), .dec_valid_o(dec_valid),
    .rr_valid_o(rr_valid), .cycle_cnt_o(cycle_cnt), .retire_cnt_o(retire_cnt)
  );

  task automatic put(input logic en, input logic [31:0] pc, input logic sq, input bit use_it);
    item_t it;
    it.en = en; it.pc = pc; it.sq = sq;
    exp_q.push_back(it);
    if (use_it && g_idx <= g_n - 8) g_use++;
    g_idx++;
  endtask

  // driver side: expected fetch stream built from the policy rules
  task automatic gen(input int m0, input int m1, input bit tk, input bit pk);
    logic [31:0] pc = RV;
    logic [31:0] np;
    int nbr = 0;
    int m;
    g_idx = 0; g_use = 0;
    while (g_idx < g_n + 4) begin
      if (!is_br(pc)) begin
        put(1'b1, pc, 1'b0, 1'b1); pc += 4;
      end else begin
        m = (nbr == 0) ? m0 : m1; nbr++;
        put(1'b1, pc, 1'b0, 1'b1);
        case (m)
          0: begin put(1'b0, 32'h0, 1'b0, 1'b0); put(1'b0, 32'h0, 1'b0, 1'b0); pc = tk ? TGT : pc + 4; end
          1: begin
            if (tk) begin put(1'b1, pc + 4, 1'b0, 1'b0); put(1'b1, pc + 8, 1'b1, 1'b0); pc = TGT; end
            else pc += 4;
          end
          2: begin put(1'b1, pc + 4, 1'b0, 1'b1); put(1'b0, 32'h0, 1'b0, 1'b0); pc = tk ? TGT : pc + 8; end
          default: begin
            np = pk ? TGT : pc + 4;
            if (pk == tk) pc = np;
            else begin
              put(1'b1, np, 1'b0, 1'b0); put(1'b1, np + 4, 1'b1, 1'b0);
              pc = tk ? TGT : pc + 4;
            end
          end
        endcase
      end
    end
  endtask

  // monitor side: pop and compare one item per cycle
  always @(negedge clk) begin
    if (mon_on) begin
      item_t it;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s cycle %0d: no expected item, actual en=%0b pc=%h", tag, mcyc, fetch_en, fetch_pc);
      end else begin
        it = exp_q.pop_front();
        if (fetch_en !== it.en || squash !== it.sq || (it.en && fetch_pc !== it.pc)) begin
          n_bad++;
          $display("FAIL %s cycle %0d: actual en=%0b pc=%h sq=%0b expected en=%0b pc=%h sq=%0b",
                   tag, mcyc, fetch_en, fetch_pc, squash, it.en, it.pc, it.sq);
        end
      end
      mcyc++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp_v, input string what);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp_v);
    end
  endtask

  task automatic run_seg(input string r, input int m0, input int m1, input bit tk, input bit pk, input int n);
    tag = r; g_n = n;
    exp_q.delete();
    gen(m0, m1, tk, pk);
    mode_i = 2'(m0); rs_taken = tk; pred_taken = pk; rs_mispred = (tk != pk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", cycle_cnt, 0, "cycle count in reset");
    chk("R1", retire_cnt, 0, "retire count in reset");
    chk("R1", {31'd0, dec_valid | rr_valid}, 0, "stage valid in reset");
    @(posedge clk); #1;
    rst = 1'b0; mcyc = 0; mon_on = 1'b1;
    @(posedge clk); #1;
    mode_i = 2'(m1);
    repeat (n - 1) begin @(posedge clk); #1; end
    mon_on = 1'b0;
    @(negedge clk);
    chk("R10", cycle_cnt, 32'(n), "cycle count");
    chk((m0 == 1 || m0 == 3) ? "R8" : "R9", retire_cnt, 32'(g_use), "retired instructions");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    run_seg("R3", 0, 0, 1'b1, 1'b0, 80);   // stall, taken
    run_seg("R3", 0, 0, 1'b0, 1'b0, 80);   // stall, not taken
    run_seg("R4", 1, 1, 1'b1, 1'b0, 80);   // sequential, taken
    run_seg("R2", 1, 1, 1'b0, 1'b0, 80);   // sequential, not taken
    run_seg("R5", 2, 2, 1'b1, 1'b0, 80);   // delay slot, taken
    run_seg("R5", 2, 2, 1'b0, 1'b0, 80);   // delay slot, not taken
    run_seg("R6", 3, 3, 1'b1, 1'b1, 80);   // predictor right, taken
    run_seg("R6", 3, 3, 1'b0, 1'b0, 80);   // predictor right, not taken
    run_seg("R7", 3, 3, 1'b1, 1'b0, 80);   // mispredict, actually taken
    run_seg("R7", 3, 3, 1'b0, 1'b1, 80);   // mispredict, actually not taken
    run_seg("R11", 0, 1, 1'b1, 1'b0, 80);  // policy changed while first branch in flight
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule